// File: doc/BRIEF.md
# Parallel Port FIFO Service Interrupt Controller

This block holds the extended control register of a parallel port that works through a shared 16-byte data FIFO. It also decides when the host must be told to service that FIFO. The host writes and reads the control byte over a simple register strobe. The FIFO supplies its fill level and a DMA terminal-count pulse. The port supplies its transfer direction and the active-low fault line from the peripheral.

A sticky service mask bit sits in the register. While the mask bit is clear, hardware sets it as soon as one of three conditions is met, and the condition that applies depends on the DMA enable bit and the port direction:
- With DMA on, the condition is a terminal count.
- In the output direction without DMA, the condition is enough free FIFO space.
- In the input direction without DMA, the condition is enough buffered data.

Setting the mask raises a one-cycle service interrupt and gates DMA off. The host re-arms the interrupt by writing the bit back to 0.

A second, separately masked path pulses an error interrupt on each falling edge of the fault line. It also pulses when the host unmasks that path while the fault line is already low. The three-bit mode field is stored and read back without further effect.

Top module: `ecp_svc_ctrl`

## Requirements
- R1: Synchronous reset leaves mode=0, error mask=0, DMA enable=0 and service mask=1, so with an empty FIFO the register reads 8'h05 and no interrupt output is high.
- R2: Register bit 0 reads 1 exactly when the fill level is 0. Bit 1 reads 1 exactly when the fill level is 16 or more. Both bits are read-only.
- R3: A register write stores bits [7:5] as the mode, bit 4 as the error mask, bit 3 as DMA enable and bit 2 as the service mask. A read returns those values in the same positions.
- R4: The DMA enable output is high only while DMA enable is 1 and the service mask is 0.
- R5: With DMA enable=1 and the service mask at 0, a terminal-count pulse sets the service mask. The service interrupt output is then high for exactly the one cycle in which the mask first reads 1.
- R6: With DMA enable=0 and direction=0 (output), the service mask is set when the free space (16 minus level) is at least the write threshold, 8 by default.
- R7: With DMA enable=0 and direction=1 (input), the service mask is set when the level is at least the read threshold, 8 by default.
- R8: A host write of 1 to the service mask raises no service interrupt. Once set, the mask stays 1 until the host writes 0.
- R9: With the error mask at 0, each high-to-low transition of the fault input gives a one-cycle error interrupt on the next cycle. With the mask at 1, the transition gives none. The mask value is taken from before the edge.
- R10: A write that changes the error mask from 1 to 0 while the fault input is low gives a one-cycle error interrupt.
- R11: In a cycle with a register write, the written service mask value wins over any hardware set condition. The condition can set the mask again from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| fifo_level | input | 5 | Bytes held in the FIFO, 0 to 16 |
| dma_tc | input | 1 | DMA terminal-count pulse |
| port_dir | input | 1 | 0 = output direction, 1 = input direction |
| fault_n | input | 1 | Active-low peripheral fault line |
| dma_en_o | output | 1 | DMA request enable |
| svc_irq_o | output | 1 | One-cycle service interrupt |
| err_irq_o | output | 1 | One-cycle error interrupt |

## Verification
The hardest case to reach is a register write that clears the service mask in the same cycle that a set condition is true. A related case is unmasking the error path while the fault line is already held low. Each has its own directed sequence. The bench holds the level above the read threshold while it clears the mask. It then drops the fault line with the error mask set and clears the mask afterwards. A long stretch of randomized level, direction, terminal-count, fault and write traffic follows, compared every cycle against a behavioural model. That stretch covers the threshold boundaries in both directions.

// File: rtl/ecp_svc_pkg.sv
package ecp_svc_pkg;

    localparam int REG_W = 8;

    typedef struct packed {
        logic [2:0] mode;
        logic       err_mask;
        logic       dma_on;
        logic       svc_mask;
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_TC    = 2'd0,
        SRC_SPACE = 2'd1,
        SRC_DATA  = 2'd2
    } svc_src_e;

    function automatic svc_src_e pick_src(input logic dma_on, input logic dir_in);
        if (dma_on)      return SRC_TC;
        else if (dir_in) return SRC_DATA;
        else             return SRC_SPACE;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] d);
        ctrl_t c;
        c.mode     = d[7:5];
        c.err_mask = d[4];
        c.dma_on   = d[3];
        c.svc_mask = d[2];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input ctrl_t c, input logic full,
                                                  input logic empty);
        return {c.mode, c.err_mask, c.dma_on, c.svc_mask, full, empty};
    endfunction

endpackage

// File: rtl/ecp_ctrl_reg.sv
module ecp_ctrl_reg
    import ecp_svc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             hw_set,
    output ctrl_t            ctrl_o
);
    ctrl_t q;
    ctrl_t wr_val;

    always_comb wr_val = unpack_ctrl(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            q.mode     <= '0;
            q.err_mask <= 1'b0;
            q.dma_on   <= 1'b0;
            q.svc_mask <= 1'b1;
        end else if (wr_en) begin
            q <= wr_val;
        end else if (hw_set) begin
            q.svc_mask <= 1'b1;
        end
    end

    assign ctrl_o = q;

    // R11
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl_o.svc_mask == $past(wdata[2])));

    // R8
    sticky_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_o.svc_mask && !wr_en) |=> ctrl_o.svc_mask);

endmodule

// File: rtl/ecp_svc_cond.sv
module ecp_svc_cond
    import ecp_svc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WR_TH = 8,
    parameter int RD_TH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic             dir_in,
    input  logic             tc,
    input  logic             dma_on,
    output logic             cond,
    output logic             full,
    output logic             empty
);
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] WR_TH_L = LVL_W'(WR_TH);
    localparam logic [LVL_W-1:0] RD_TH_L = LVL_W'(RD_TH);

    logic [LVL_W-1:0] free_cnt;
    svc_src_e         src;

    always_comb begin
        free_cnt = (level >= DEPTH_L) ? '0 : DEPTH_L - level;
        src      = pick_src(dma_on, dir_in);
        unique case (src)
            SRC_TC:    cond = tc;
            SRC_SPACE: cond = (free_cnt >= WR_TH_L);
            SRC_DATA:  cond = (level >= RD_TH_L);
            default:   cond = 1'b0;
        endcase
        full  = (level >= DEPTH_L);
        empty = (level == '0);
    end

    // R2
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R2
    level_range_chk: assert property (@(posedge clk) disable iff (rst)
        level <= DEPTH_L);

endmodule

// File: rtl/ecp_fault_edge.sv
module ecp_fault_edge (
    input  logic clk,
    input  logic rst,
    input  logic fault_n,
    input  logic err_mask,
    input  logic wr_en,
    input  logic wr_mask_val,
    output logic err_pulse
);
    logic fault_q;
    logic fall_hit;
    logic unmask_hit;

    always_comb begin
        fall_hit   = !err_mask && fault_q && !fault_n;
        unmask_hit = wr_en && err_mask && !wr_mask_val && !fault_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q   <= 1'b1;
            err_pulse <= 1'b0;
        end else begin
            fault_q   <= fault_n;
            err_pulse <= fall_hit || unmask_hit;
        end
    end

    // R9
    pulse_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> !$past(fault_n));

    // R9
    edge_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (!err_mask && fault_q && !fault_n) |=> err_pulse);

    // R10
    unmask_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && err_mask && !wr_mask_val && !fault_n) |=> err_pulse);

endmodule

// File: rtl/ecp_svc_ctrl.sv
module ecp_svc_ctrl
    import ecp_svc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WR_TH = 8,
    parameter int RD_TH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             dma_tc,
    input  logic             port_dir,
    input  logic             fault_n,
    output logic             dma_en_o,
    output logic             svc_irq_o,
    output logic             err_irq_o
);
    ctrl_t ctrl;
    logic  cond;
    logic  full;
    logic  empty;
    logic  hw_set;

    assign hw_set = cond && !ctrl.svc_mask;

    ecp_svc_cond #(
        .DEPTH (DEPTH),
        .WR_TH (WR_TH),
        .RD_TH (RD_TH),
        .LVL_W (LVL_W)
    ) u_cond (
        .clk    (clk),
        .rst    (rst),
        .level  (fifo_level),
        .dir_in (port_dir),
        .tc     (dma_tc),
        .dma_on (ctrl.dma_on),
        .cond   (cond),
        .full   (full),
        .empty  (empty)
    );

    ecp_ctrl_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr),
        .wdata  (reg_wdata),
        .hw_set (hw_set),
        .ctrl_o (ctrl)
    );

    ecp_fault_edge u_fault (
        .clk         (clk),
        .rst         (rst),
        .fault_n     (fault_n),
        .err_mask    (ctrl.err_mask),
        .wr_en       (reg_wr),
        .wr_mask_val (reg_wdata[4]),
        .err_pulse   (err_irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) svc_irq_o <= 1'b0;
        else     svc_irq_o <= hw_set && !reg_wr;
    end

    assign dma_en_o  = ctrl.dma_on && !ctrl.svc_mask;
    assign reg_rdata = pack_reg(ctrl, full, empty);

    // R5
    svc_irq_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        svc_irq_o |-> (ctrl.svc_mask && !$past(ctrl.svc_mask)));

    // R8
    host_set_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[2]) |=> !svc_irq_o);

    // R5
    tc_sets_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.dma_on && !ctrl.svc_mask && dma_tc && !reg_wr) |=> (ctrl.svc_mask && svc_irq_o));

    // R4
    dma_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_irq_o || !ctrl.dma_on) |-> !dma_en_o);

endmodule

// File: tb/ecp_svc_ctrl_test.sv
`timescale 1ns/1ps
module ecp_svc_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] fifo_level = '0;
    logic       dma_tc = 1'b0;
    logic       port_dir = 1'b0;
    logic       fault_n = 1'b1;
    logic       dma_en_o, svc_irq_o, err_irq_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    ecp_svc_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fifo_level(fifo_level), .dma_tc(dma_tc),
        .port_dir(port_dir), .fault_n(fault_n), .dma_en_o(dma_en_o),
        .svc_irq_o(svc_irq_o), .err_irq_o(err_irq_o)
    );

    // behavioural reference
    int m_mode, m_emask, m_dma, m_svc, m_pf, m_si, m_ei;
    always @(posedge clk) begin
        int lvl;
        bit c;
        lvl = int'(fifo_level);
        if (rst) begin
            m_mode <= 0; m_emask <= 0; m_dma <= 0; m_svc <= 1;
            m_pf <= 1; m_si <= 0; m_ei <= 0;
        end else begin
            if (m_dma != 0)    c = (dma_tc == 1'b1);
            else if (port_dir) c = (lvl >= 8);
            else               c = ((16 - lvl) >= 8);
            m_si <= (!reg_wr && m_svc == 0 && c) ? 1 : 0;
            if (reg_wr) m_svc <= int'(reg_wdata[2]);
            else if (c) m_svc <= 1;
            m_ei <= ((m_emask == 0 && m_pf == 1 && !fault_n) ||
                     (reg_wr && m_emask == 1 && !reg_wdata[4] && !fault_n)) ? 1 : 0;
            m_pf <= int'(fault_n);
            if (reg_wr) begin
                m_mode  <= int'(reg_wdata[7:5]);
                m_emask <= int'(reg_wdata[4]);
                m_dma   <= int'(reg_wdata[3]);
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata();
        int l;
        l = int'(fifo_level);
        return (m_mode << 5) | (m_emask << 4) | (m_dma << 3) | (m_svc << 2) |
               ((l >= 16 ? 1 : 0) << 1) | (l == 0 ? 1 : 0);
    endfunction

    // every-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(int'(reg_rdata), exp_rdata(), "R3/R2 rdata");
            chk(int'(dma_en_o), (m_dma == 1 && m_svc == 0) ? 1 : 0, "R4 dma_en");
            chk(int'(svc_irq_o), m_si, "R5-R8 svc_irq");
            chk(int'(err_irq_o), m_ei, "R9/R10 err_irq");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wreg(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic at_neg();
        @(negedge clk); #1;
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        at_neg();
        chk(int'(reg_rdata), 8'h05, "R1 reset rdata");
        chk(int'(svc_irq_o) + int'(err_irq_o) + int'(dma_en_o), 0, "R1 outputs idle");
        tick(0);

        // R2 levels
        fifo_level = 5'd16; at_neg();
        chk(int'(reg_rdata[1:0]), 2, "R2 full");
        fifo_level = 5'd5; at_neg();
        chk(int'(reg_rdata[1:0]), 0, "R2 partial");
        tick(0);

        // R3 store/readback, input direction with low level so nothing sets
        port_dir = 1'b1; fifo_level = 5'd0;
        tick(1);
        wreg(8'hB0);
        at_neg();
        chk(int'(reg_rdata), 8'hB1, "R3 readback");
        tick(1);

        // R7 input threshold: 7 no, 8 yes
        fifo_level = 5'd7; tick(2);
        chk(int'(reg_rdata[2]), 0, "R7 below threshold");
        fifo_level = 5'd8; tick(1);
        at_neg();
        chk(int'(reg_rdata[2]), 1, "R7 set at threshold");
        chk(int'(svc_irq_o), 1, "R7 pulse");
        tick(1);
        chk(int'(svc_irq_o), 0, "R8 single pulse");

        // R8 host write of 1: no pulse, and stays set
        fifo_level = 5'd0;
        wreg(8'h04);
        tick(0);
        chk(int'(svc_irq_o), 0, "R8 host write quiet");
        tick(3);
        chk(int'(reg_rdata[2]), 1, "R8 sticky");

        // R6 output threshold: free 7 no, free 8 yes
        port_dir = 1'b0; fifo_level = 5'd9;
        wreg(8'h00);
        tick(2);
        chk(int'(reg_rdata[2]), 0, "R6 free below threshold");
        fifo_level = 5'd8; tick(1);
        at_neg();
        chk(int'(svc_irq_o), 1, "R6 pulse at threshold");
        tick(1);

        // R5 terminal count with DMA
        fifo_level = 5'd16;
        wreg(8'h08);
        at_neg();
        chk(int'(dma_en_o), 1, "R4 dma enabled");
        tick(0);
        dma_tc = 1'b1; tick(1); dma_tc = 1'b0;
        at_neg();
        chk(int'(svc_irq_o), 1, "R5 tc pulse");
        chk(int'(dma_en_o), 0, "R4 dma gated by mask");
        tick(1);

        // R11 clear while condition true
        port_dir = 1'b1; fifo_level = 5'd12;
        wreg(8'h00);
        at_neg();
        chk(int'(reg_rdata[2]), 0, "R11 write wins");
        chk(int'(svc_irq_o), 0, "R11 no pulse in write cycle");
        tick(1);
        at_neg();
        chk(int'(svc_irq_o), 1, "R11 re-set next cycle");
        tick(1);

        // R9 fault edges
        fifo_level = 5'd0;
        fault_n = 1'b0; tick(1);
        at_neg();
        chk(int'(err_irq_o), 1, "R9 edge pulse");
        tick(0);
        fault_n = 1'b1; tick(1);
        wreg(8'h14);
        fault_n = 1'b0; tick(1);
        at_neg();
        chk(int'(err_irq_o), 0, "R9 masked edge");
        tick(1);

        // R10 unmask while low
        wreg(8'h04);
        at_neg();
        chk(int'(err_irq_o), 1, "R10 unmask pulse");
        tick(1);
        fault_n = 1'b1;

        // randomized traffic checked by the reference every cycle
        for (int i = 0; i < 3000; i++) begin
            fifo_level = 5'($urandom_range(0, 16));
            port_dir   = 1'($urandom_range(0, 1));
            dma_tc     = ($urandom_range(0, 7) == 0);
            fault_n    = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 5) == 0) begin
                reg_wr = 1'b1; reg_wdata = 8'($urandom_range(0, 255));
            end else begin
                reg_wr = 1'b0;
            end
            tick(1);
        end
        reg_wr = 1'b0; dma_tc = 1'b0;
        tick(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule